// File: doc/BRIEF.md
# Serial Management Slave with PHY Register File

This block is the management end of a PHY. A station manager reaches it over a two-wire serial link with a clock and a shared data line. The block runs entirely on the management clock, sampling the data line on each rising edge. It drives its side of the data line through a separate output and an output-enable, so the pad and the pull-up stay outside. The block decodes frames that carry its strapped 5-bit address and answers reads and writes against a small register file. The register file holds control, status, identifier and one vendor status register.

The register file mixes several bit kinds. Plain read/write bits hold configuration. Read-only bits report fixed capabilities. A self-clearing bit triggers a software reset. Sticky bits hold link and error events until the station reads them. One status bit can be overwritten, and it enables frames that arrive without a preamble. Status inputs come from the PHY datapath, which in this project is stimulus.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is a start pair 0 then 1, a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, all sent most significant bit first and sampled on the rising clock edge. With suppression off, a start is accepted only after at least 32 consecutive ones.
- R2: For opcode 10 (read) to the strapped address, the enable stays low through the first turnaround bit. It goes high with a 0 driven for the second turnaround bit, then carries data bits 15 down to 0, one per clock. It drops after bit 0.
- R3: For opcode 01 (write) to the strapped address, the enable never goes high, and the 16 data bits are written to the addressed register subject to its bit types.
- R4: Opcodes 00 and 11 are ignored: no drive and no register change. The slave then waits for a fresh preamble or start.
- R5: A frame whose PHY address differs from the strap is ignored. Its remaining 18 bits are not searched for a new start.
- R6: Register 1 bit 6 (preamble-suppression enable) resets to 0 and is writable. While it is 1, a frame that begins with the start pair and no preamble is accepted.
- R7: Writing 1 to register 0 bit 15 restores every register to its default, including bit 6 of register 1 and all sticky bits. Bit 15 then clears itself on the next clock.
- R8: Latching-high bits are register 1 bit 4 (remote fault), register 1 bit 1 (jabber), register 17 bit 9 (symbol error) and register 17 bit 5 (early end). Each goes to 1 on a one-cycle event pulse and holds until a read of its register reports it. A read re-arms the bit.
- R9: Register 1 bit 2 and register 17 bit 2 report link-up as latching-low bits. Each reads 0 after any cycle with the link input low, until a read of its own register reports that 0.
- R10: Register 2 reads the identifier parameter. Register 3 reads {6-bit OUI part, model number 000101 in bits 9:4, 4-bit revision in bits 3:0}.
- R11: Register 0 has writable bits 14 (loopback), 13 (speed, default 1), 12 (negotiation enable, default 1) and 8 (duplex, default 0), and all its other bits read 0. Register 1 reads constant ones in bits 14:11, 3 and 0. Writes to read-only bits, to registers 2, 3 and 17, and to unused addresses change nothing, and unused addresses read 0.
- R12: Register 1 bit 5 and register 17 bit 4 follow the negotiation-done input live. Register 17 bits 15 and 14 mirror register 0 bits 13 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr | input | 5 | Strapped PHY address |
| mdio_in | input | 1 | Data line as seen at the pad |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| link_ok | input | 1 | Current link state from the datapath |
| jabber_evt | input | 1 | Jabber event pulse |
| rfault_evt | input | 1 | Remote fault event pulse |
| sym_err_evt | input | 1 | Invalid symbol event pulse |
| early_end_evt | input | 1 | Premature stream end event pulse |
| an_done | input | 1 | Negotiation complete level |

## Verification
A framer that has lost bit alignment shows up within one frame at the ports. The enable rises in the wrong bit slot or on a frame meant for another address, and the bench compares the enable and data line on every clock of every frame. A sticky flag that drops early, clears twice or ignores a software reset first shows as a wrong bit in the next read of that register. Back-to-back reads of the same register therefore expose it within two frames. A write that lands in a read-only or unused location is caught by the read that follows it.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the serial management slave.
// Assumes a 16-bit data field and 5-bit addresses, fixed by the frame format.
package mdio_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_HDR, S_TA1, S_TA2, S_DATA, S_SKIP
    } mdio_state_e;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [4:0] A_CTRL  = 5'd0;
    localparam logic [4:0] A_STAT  = 5'd1;
    localparam logic [4:0] A_ID1   = 5'd2;
    localparam logic [4:0] A_ID2   = 5'd3;
    localparam logic [4:0] A_VSTAT = 5'd17;
endpackage

// File: rtl/mdio_sticky.sv
// One sticky status bit. It latches an event and holds it until a read
// clears it. HIGH_ACTIVE=1 gives a latching-high bit. HIGH_ACTIVE=0 gives a
// latching-low bit that reads 0 once the raw input was seen low.
// Assumes clear is high only in the cycle a read captures the value.
module mdio_sticky #(
    parameter bit HIGH_ACTIVE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic clear,
    input  logic raw,
    output logic value
);
    logic hit;
    logic seen_q;

    assign hit = HIGH_ACTIVE ? raw : ~raw;

    // Capture events; a new event in the clearing cycle wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) seen_q <= 1'b0;
        else                seen_q <= hit | (seen_q & ~clear);
    end

    assign value = HIGH_ACTIVE ? seen_q : ~seen_q;

    // R8
    hold_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hit) && !$past(wipe)) |-> seen_q);
endmodule

// File: rtl/mdio_frame_ctl.sv
// Serial frame engine. It counts preamble ones, finds the start pair and
// decodes opcode and addresses. It then either shifts read data out with the
// turnaround zero, collects write data, or skips a frame for another PHY.
// Assumes the station samples our output on the rising edge after we drive it.
module mdio_frame_ctl
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DW      = DATA_W,
    parameter int AW      = ADDR_W
) (
    input  logic          mdc,
    input  logic          rst_n,
    input  logic [AW-1:0] phy_addr,
    input  logic          pre_skip_en,
    input  logic          mdio_in,
    output logic          mdio_out,
    output logic          mdio_oe,
    output logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] rd_data,
    output logic          rd_take,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data
);
    localparam int HDR_LEN  = 2 + 2 * AW;
    localparam int SKIP_LEN = 2 + DW;
    localparam int CNT_MAX  = (PRE_LEN > SKIP_LEN) ? PRE_LEN : SKIP_LEN;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DW - 1);
    localparam logic [CNT_W-1:0] SKIP_END = CNT_W'(SKIP_LEN - 1);

    mdio_state_e          state;
    logic [CNT_W-1:0]     cnt;
    logic [HDR_LEN-2:0]   hdr;
    logic [HDR_LEN-1:0]   hdr_next;
    logic [1:0]           op;
    logic [AW-1:0]        pa;
    logic [DW-1:0]        sh;
    logic                 is_rd;
    logic                 op_ok;

    assign hdr_next = {hdr, mdio_in};
    assign op       = hdr_next[HDR_LEN-1 -: 2];
    assign pa       = hdr_next[2*AW-1 -: AW];
    assign op_ok    = (op == OP_RD) || (op == OP_WR);
    assign rd_take  = (state == S_TA1) && is_rd;

    // Frame sequencing, output drive and write capture.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            hdr      <= '0;
            sh       <= '0;
            is_rd    <= 1'b0;
            reg_addr <= '0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (mdio_in) begin
                        if (cnt != PRE_END) cnt <= cnt + 1'b1;
                    end else begin
                        cnt <= '0;
                        if (cnt == PRE_END || pre_skip_en) state <= S_START;
                    end
                end
                S_START: begin
                    cnt   <= '0;
                    state <= mdio_in ? S_HDR : S_IDLE;
                end
                S_HDR: begin
                    hdr <= hdr_next[HDR_LEN-2:0];
                    if (cnt == HDR_END) begin
                        cnt <= '0;
                        if (op_ok && pa == phy_addr) begin
                            is_rd    <= (op == OP_RD);
                            reg_addr <= hdr_next[AW-1:0];
                            state    <= S_TA1;
                        end else if (op_ok) begin
                            state <= S_SKIP;
                        end else begin
                            state <= S_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_TA1: begin
                    if (is_rd) begin
                        mdio_oe  <= 1'b1;
                        mdio_out <= 1'b0;
                        sh       <= rd_data;
                    end
                    state <= S_TA2;
                end
                S_TA2: begin
                    if (is_rd) begin
                        mdio_out <= sh[DW-1];
                        sh       <= sh << 1;
                    end
                    cnt   <= '0;
                    state <= S_DATA;
                end
                S_DATA: begin
                    if (is_rd) begin
                        if (cnt == DATA_END) begin
                            mdio_oe  <= 1'b0;
                            mdio_out <= 1'b0;
                            cnt      <= '0;
                            state    <= S_IDLE;
                        end else begin
                            mdio_out <= sh[DW-1];
                            sh       <= sh << 1;
                            cnt      <= cnt + 1'b1;
                        end
                    end else begin
                        sh <= {sh[DW-2:0], mdio_in};
                        if (cnt == DATA_END) begin
                            wr_stb  <= 1'b1;
                            wr_data <= {sh[DW-2:0], mdio_in};
                            cnt     <= '0;
                            state   <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_SKIP: begin
                    if (cnt == SKIP_END) begin
                        cnt   <= '0;
                        state <= S_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2
    ta_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        rd_take |=> (mdio_oe && !mdio_out));
    // R2
    release_idle_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> (state == S_IDLE));
    // R3
    write_quiet_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        wr_stb |-> !mdio_oe);
    // R5
    skip_quiet_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (state == S_SKIP) |-> !mdio_oe);
endmodule

// File: rtl/mdio_regs.sv
// Management register file. It holds control, status, two identifier words
// and vendor status, with read/write, read-only, self-clearing, override and
// sticky bits. Assumes rd_take marks the cycle in which a read value is taken.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int          DW     = DATA_W,
    parameter int          AW     = ADDR_W,
    parameter logic [15:0] ID_HI  = 16'h0015,
    parameter logic [5:0]  OUI_LO = 6'h2A,
    parameter logic [5:0]  MODEL  = 6'd5,
    parameter logic [3:0]  REV    = 4'h3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_take,
    output logic [DW-1:0] rd_data,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pre_skip_en,
    input  logic          link_ok,
    input  logic          jabber_evt,
    input  logic          rfault_evt,
    input  logic          sym_err_evt,
    input  logic          early_end_evt,
    input  logic          an_done
);
    localparam int          N_STICKY    = 6;
    localparam logic [15:0] CTL_DEF     = 16'h3000;
    localparam logic [15:0] CTL_RW_MASK = 16'h7100;
    localparam logic [15:0] STAT_FIXED  = 16'h7809;
    // Sticky slots: 0 remote fault, 1 jabber, 2 link (reg 1);
    // 3 symbol error, 4 early end, 5 link (reg 17).
    localparam logic [N_STICKY-1:0] HIGH_MAP = 6'b011011;

    logic [15:0]         ctl_q;
    logic                rst_pend;
    logic                psup_q;
    logic [N_STICKY-1:0] raw_v;
    logic [N_STICKY-1:0] clr_v;
    logic [N_STICKY-1:0] stk;

    // Writable control bits, the self-clearing reset and the override bit.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_pend) begin
            ctl_q    <= CTL_DEF;
            psup_q   <= 1'b0;
            rst_pend <= 1'b0;
        end else if (wr_stb) begin
            if (wr_addr == A_CTRL) begin
                ctl_q    <= wr_data & CTL_RW_MASK;
                rst_pend <= wr_data[15];
            end else if (wr_addr == A_STAT) begin
                psup_q <= wr_data[6];
            end
        end
    end

    assign pre_skip_en = psup_q;
    assign raw_v = {link_ok, early_end_evt, sym_err_evt, link_ok, jabber_evt, rfault_evt};
    assign clr_v = {{3{rd_take && rd_addr == A_VSTAT}}, {3{rd_take && rd_addr == A_STAT}}};

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        mdio_sticky #(.HIGH_ACTIVE(HIGH_MAP[i])) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .wipe  (rst_pend),
            .clear (clr_v[i]),
            .raw   (raw_v[i]),
            .value (stk[i])
        );
    end

    // Read multiplexer assembling each register image.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  rd_data = {rst_pend, ctl_q[14:0]};
            A_STAT: begin
                rd_data    = STAT_FIXED;
                rd_data[6] = psup_q;
                rd_data[5] = an_done;
                rd_data[4] = stk[0];
                rd_data[2] = stk[2];
                rd_data[1] = stk[1];
            end
            A_ID1:   rd_data = ID_HI;
            A_ID2:   rd_data = {OUI_LO, MODEL, REV};
            A_VSTAT: begin
                rd_data[15] = ctl_q[13];
                rd_data[14] = ctl_q[8];
                rd_data[9]  = stk[3];
                rd_data[5]  = stk[4];
                rd_data[4]  = an_done;
                rd_data[2]  = stk[5];
            end
            default: rd_data = '0;
        endcase
    end

    // R7
    soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend |=> (!rst_pend && ctl_q == CTL_DEF && !psup_q));
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Top of the serial management slave. It joins the frame engine to the
// register file. Assumes the pad merges mdio_out/mdio_oe with a pull-up and
// returns the line level on mdio_in.
module mdio_mgmt_slave
    import mdio_pkg::*;
#(
    parameter int          PRE_LEN = 32,
    parameter logic [15:0] ID_HI   = 16'h0015,
    parameter logic [5:0]  OUI_LO  = 6'h2A,
    parameter logic [3:0]  REV     = 4'h3
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              link_ok,
    input  logic              jabber_evt,
    input  logic              rfault_evt,
    input  logic              sym_err_evt,
    input  logic              early_end_evt,
    input  logic              an_done
);
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] wr_data;
    logic              rd_take;
    logic              wr_stb;
    logic              pre_skip_en;

    mdio_frame_ctl #(.PRE_LEN(PRE_LEN), .DW(DATA_W), .AW(ADDR_W)) u_frame (
        .mdc         (mdc),
        .rst_n       (rst_n),
        .phy_addr    (phy_addr),
        .pre_skip_en (pre_skip_en),
        .mdio_in     (mdio_in),
        .mdio_out    (mdio_out),
        .mdio_oe     (mdio_oe),
        .reg_addr    (reg_addr),
        .rd_data     (rd_data),
        .rd_take     (rd_take),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data)
    );

    mdio_regs #(
        .DW(DATA_W), .AW(ADDR_W), .ID_HI(ID_HI), .OUI_LO(OUI_LO),
        .MODEL(6'd5), .REV(REV)
    ) u_regs (
        .clk           (mdc),
        .rst_n         (rst_n),
        .rd_addr       (reg_addr),
        .rd_take       (rd_take),
        .rd_data       (rd_data),
        .wr_stb        (wr_stb),
        .wr_addr       (reg_addr),
        .wr_data       (wr_data),
        .pre_skip_en   (pre_skip_en),
        .link_ok       (link_ok),
        .jabber_evt    (jabber_evt),
        .rfault_evt    (rfault_evt),
        .sym_err_evt   (sym_err_evt),
        .early_end_evt (early_end_evt),
        .an_done       (an_done)
    );
endmodule

// File: tb/mdio_mgmt_slave_test.sv
// Bench: a behavioural station plus a register model. Every clock of every
// frame compares the drive enable and data line with the model's prediction.
module mdio_mgmt_slave_test;
    localparam time         CLK_PERIOD = 10ns;
    localparam logic [4:0]  PHY        = 5'h0B;
    localparam logic [15:0] ID_HI      = 16'h0015;
    localparam logic [5:0]  OUI_LO     = 6'h2A;
    localparam logic [3:0]  REV        = 4'h3;

    logic mdc = 1'b0, rst_n = 1'b0, mdio_in = 1'b1;
    logic mdio_out, mdio_oe;
    logic link_ok = 1'b1, jabber_evt = 1'b0, rfault_evt = 1'b0;
    logic sym_err_evt = 1'b0, early_end_evt = 1'b0, an_done = 1'b0;

    int tests = 0, fails = 0;

    // Register model state
    logic [15:0] m_ctl = 16'h3000;
    logic m_psup = 0, m_rf = 0, m_jab = 0, m_ls1 = 0, m_sym = 0, m_early = 0, m_ls17 = 0;

    mdio_mgmt_slave #(.ID_HI(ID_HI), .OUI_LO(OUI_LO), .REV(REV)) uut (
        .mdc(mdc), .rst_n(rst_n), .phy_addr(PHY), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .link_ok(link_ok),
        .jabber_evt(jabber_evt), .rfault_evt(rfault_evt), .sym_err_evt(sym_err_evt),
        .early_end_evt(early_end_evt), .an_done(an_done)
    );

    initial forever #(CLK_PERIOD / 2) mdc = ~mdc;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_reg(input logic [4:0] ra);
        logic [15:0] v;
        v = 16'h0000;
        case (ra)
            5'd0: v = m_ctl;
            5'd1: begin
                v = 16'h7809; v[6] = m_psup; v[5] = an_done; v[4] = m_rf;
                v[2] = ~m_ls1; v[1] = m_jab;
            end
            5'd2: v = ID_HI;
            5'd3: v = {OUI_LO, 6'b000101, REV};
            5'd17: begin
                v[15] = m_ctl[13]; v[14] = m_ctl[8]; v[9] = m_sym;
                v[5] = m_early; v[4] = an_done; v[2] = ~m_ls17;
            end
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

    task automatic model_defaults();
        m_ctl = 16'h3000; m_psup = 0; m_rf = 0; m_jab = 0; m_ls1 = 0;
        m_sym = 0; m_early = 0; m_ls17 = 0;
    endtask

    // Sends one frame, checks the line every clock and updates the model.
    task automatic run_frame(input string req, input bit pre, input logic [1:0] op,
                             input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd);
        bit q[$];
        int p;
        bit hit, is_rd, ok;
        logic [15:0] exp_d, got;
        hit   = (op == 2'b10 || op == 2'b01) && pa == PHY && (pre || m_psup);
        is_rd = hit && op == 2'b10;
        exp_d = exp_reg(ra);
        got   = 16'h0000;
        ok    = 1'b1;
        if (pre) for (int k = 0; k < 32; k++) q.push_back(1'b1);
        else begin q.push_back(1'b0); q.push_back(1'b0); end
        p = q.size();
        q.push_back(1'b0); q.push_back(1'b1);
        q.push_back(op[1]); q.push_back(op[0]);
        for (int k = 4; k >= 0; k--) q.push_back(pa[k]);
        for (int k = 4; k >= 0; k--) q.push_back(ra[k]);
        if (op == 2'b01) begin q.push_back(1'b1); q.push_back(1'b0); end
        else begin q.push_back(1'b1); q.push_back(1'b1); end
        for (int k = 15; k >= 0; k--) q.push_back(op == 2'b10 ? 1'b1 : wd[k]);
        for (int k = 0; k < 4; k++) q.push_back(1'b1);
        for (int i = 0; i < q.size(); i++) begin
            bit eoe, eout;
            @(negedge mdc);
            eoe = 1'b0; eout = 1'b0;
            if (is_rd && i == p + 15) eoe = 1'b1;
            if (is_rd && i >= p + 16 && i <= p + 31) begin
                eoe = 1'b1; eout = exp_d[15 - (i - p - 16)];
                got[15 - (i - p - 16)] = mdio_out;
            end
            if (mdio_oe !== eoe || (eoe && mdio_out !== eout)) begin
                if (ok) $display("FAIL %s line at bit %0d: actual oe=%b out=%b expected oe=%b out=%b",
                                 req, i, mdio_oe, mdio_out, eoe, eout);
                ok = 1'b0;
            end
            mdio_in = q[i];
        end
        tests++;
        if (!ok) fails++;
        if (is_rd) begin
            check(got == exp_d, req, $sformatf("read data reg %0d", ra), got, exp_d);
            if (ra == 5'd1) begin m_rf = 0; m_jab = 0; m_ls1 = 0; end
            if (ra == 5'd17) begin m_sym = 0; m_early = 0; m_ls17 = 0; end
        end else if (hit) begin
            if (ra == 5'd0) begin
                if (wd[15]) model_defaults();
                else m_ctl = wd & 16'h7100;
            end
            if (ra == 5'd1) m_psup = wd[6];
        end
    endtask

    task automatic rd(input string req, input logic [4:0] ra);
        run_frame(req, 1'b1, 2'b10, PHY, ra, 16'h0000);
    endtask

    task automatic wr(input string req, input logic [4:0] ra, input logic [15:0] d);
        run_frame(req, 1'b1, 2'b01, PHY, ra, d);
    endtask

    task automatic pulse(input int which);
        @(negedge mdc);
        case (which)
            0: begin rfault_evt = 1; m_rf = 1; end
            1: begin jabber_evt = 1; m_jab = 1; end
            2: begin link_ok = 0; m_ls1 = 1; m_ls17 = 1; end
            3: begin sym_err_evt = 1; m_sym = 1; end
            default: begin early_end_evt = 1; m_early = 1; end
        endcase
        @(negedge mdc);
        rfault_evt = 0; jabber_evt = 0; link_ok = 1; sym_err_evt = 0; early_end_evt = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge mdc);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
        check(mdio_oe == 1'b0, "R2", "reset enable", {15'b0, mdio_oe}, 16'h0000);
        // Identifier and defaults
        rd("R10", 5'd2);
        rd("R10", 5'd3);
        rd("R11", 5'd0);
        rd("R11", 5'd1);
        rd("R12", 5'd17);
        // Writes: masked control bits, read-only register, unused address
        wr("R11", 5'd0, 16'h7FFF);
        rd("R11", 5'd0);
        rd("R12", 5'd17);
        wr("R3", 5'd0, 16'h5A5A);
        rd("R3", 5'd0);
        wr("R11", 5'd2, 16'h1234);
        rd("R11", 5'd2);
        wr("R11", 5'd9, 16'hFFFF);
        rd("R11", 5'd9);
        // Foreign address and invalid opcodes
        run_frame("R5", 1'b1, 2'b01, PHY ^ 5'h01, 5'd0, 16'h0000);
        run_frame("R5", 1'b1, 2'b10, PHY ^ 5'h10, 5'd0, 16'h0000);
        rd("R5", 5'd0);
        run_frame("R4", 1'b1, 2'b00, PHY, 5'd0, 16'h0000);
        run_frame("R4", 1'b1, 2'b11, PHY, 5'd0, 16'h0000);
        rd("R4", 5'd0);
        // No preamble without suppression enabled
        run_frame("R1", 1'b0, 2'b10, PHY, 5'd0, 16'h0000);
        run_frame("R1", 1'b0, 2'b01, PHY, 5'd0, 16'h0000);
        rd("R1", 5'd0);
        // Enable suppression
        wr("R6", 5'd1, 16'hFFFF);
        run_frame("R6", 1'b0, 2'b10, PHY, 5'd0, 16'h0000);
        run_frame("R6", 1'b0, 2'b01, PHY, 5'd0, 16'h1100);
        run_frame("R6", 1'b0, 2'b10, PHY, 5'd1, 16'h0000);
        // Sticky bits in register 1
        pulse(0); pulse(1); pulse(2);
        rd("R8", 5'd1);
        rd("R9", 5'd1);
        // Sticky bits in register 17 (link drop above still pending there)
        pulse(3); pulse(4);
        rd("R8", 5'd17);
        rd("R9", 5'd17);
        // Live negotiation-done level
        @(negedge mdc); an_done = 1'b1;
        rd("R12", 5'd1);
        rd("R12", 5'd17);
        // Software reset restores everything
        pulse(1); pulse(3);
        wr("R7", 5'd0, 16'hC000);
        rd("R7", 5'd0);
        rd("R7", 5'd1);
        rd("R7", 5'd17);
        run_frame("R7", 1'b0, 2'b10, PHY, 5'd0, 16'h0000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule